// File: doc/BRIEF.md
# External Bus Hold Handshake Controller

This block decides who owns a shared external memory bus. Normally the chip's internal bus master drives it. An outside device can ask for the bus by pulling an active-low hold request. The block passes that request through a synchronizer. It then waits until the internal side has no access in flight and nothing queued. Only then does it answer with an active-low hold acknowledge. In the same cycle it turns off the output enable for every address, data and strobe pad.

While the outside device holds the bus, a stall output keeps the internal master from starting new accesses. Those accesses stay queued. When the outside device lets go of its request, the block first deasserts the acknowledge and turns the pad drivers back on. It keeps the stall for one more cycle, so the internal side cannot start an access in the same cycle that bus ownership changes.

Top module: `bus_hold_arbiter`

## Requirements
- R1: During and right after synchronous reset, `hold_ack_n` is 1, `bus_drive_en` is 1 and `int_stall` is 0. A request input held high (the pulled-up idle level) never produces a grant.
- R2: The request passes through two synchronizer flops. If `hold_req_n` goes low while the internal side is idle, `hold_ack_n` falls after exactly the third rising clock edge, and not before.
- R3: No grant is given while `acc_busy` is 1. The grant follows on the first rising edge after `acc_busy` returns to 0, provided the pending count is also zero.
- R4: No grant is given while `pend_cnt` is nonzero. The grant follows on the first rising edge after the count reaches zero, provided no access is busy.
- R5: While `hold_ack_n` is 0, `bus_drive_en` is 0 (all bus and strobe pads at high impedance) and `int_stall` is 1.
- R6: Once granted, the acknowledge stays low for as long as the request stays low, whatever `acc_busy` and `pend_cnt` do.
- R7: When the request is released, `hold_ack_n` rises after the third rising edge, with `bus_drive_en` 1 and `int_stall` still 1 in that cycle. `int_stall` drops to 0 one cycle later.
- R8: If the request is withdrawn while the block is still waiting for the internal side to go idle, no grant is ever issued. After that, the internal side going idle does not produce a grant either.
- R9: While the block is waiting for idle, `int_stall` stays 0 and `bus_drive_en` stays 1, so queued accesses can drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req_n | input | 1 | Active-low bus hold request from the outside device (asynchronous) |
| acc_busy | input | 1 | 1 while an internal bus access is in flight |
| pend_cnt | input | PEND_W | Number of internal accesses waiting to start |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| bus_drive_en | output | 1 | 1 = internal pads drive address, data and strobes; 0 = high impedance |
| int_stall | output | 1 | 1 = internal master must not start a new access |

## Verification
The bench measures grant and release latency to the exact edge. A design with one synchronizer stage too few or too many answers a cycle early or late, and the bench reports it. It holds the grant back separately with a busy access and with a nonzero queue, including a queue that counts down through nonzero values. A design that checks only one of the two conditions, or only the low bit of the count, hands over the bus while an access is unfinished. It also looks at the release cycle by cycle. A design that drops the stall together with the acknowledge would let a new access start as ownership changes. Last, it withdraws a request during the drain, which catches a design that latches the request and grants later.

// File: rtl/bha_pkg.sv
package bha_pkg;

    typedef enum logic [1:0] {
        ST_OWN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_GRANT = 2'd2,
        ST_REARM = 2'd3
    } bha_state_e;

    typedef struct packed {
        logic ack_n;
        logic drive_en;
        logic stall;
    } bha_out_t;

    function automatic bha_out_t bha_decode(bha_state_e st);
        bha_out_t o;
        o.ack_n    = 1'b1;
        o.drive_en = 1'b1;
        o.stall    = 1'b0;
        case (st)
            ST_GRANT: begin
                o.ack_n    = 1'b0;
                o.drive_en = 1'b0;
                o.stall    = 1'b1;
            end
            ST_REARM: o.stall = 1'b1;
            default:  ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n_async,
    output logic req_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= ~req_n_async;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign req_sync = chain[STAGES-1];
endmodule

// File: rtl/bha_idle.sv
module bha_idle #(
    parameter int PEND_W = 4
) (
    input  logic              acc_busy,
    input  logic [PEND_W-1:0] pend_cnt,
    output logic              idle
);
    localparam logic [PEND_W-1:0] NONE = '0;
    assign idle = !acc_busy && (pend_cnt == NONE);
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
    import bha_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  logic     idle,
    output bha_out_t outs
);
    bha_state_e state, nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_OWN:   if (req) nxt = idle ? ST_GRANT : ST_DRAIN;
            ST_DRAIN: if (!req) nxt = ST_OWN;
                      else if (idle) nxt = ST_GRANT;
            ST_GRANT: if (!req) nxt = ST_REARM;
            ST_REARM: nxt = ST_OWN;
            default:  nxt = ST_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OWN;
        else     state <= nxt;
    end

    assign outs = bha_decode(state);
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
    import bha_pkg::*;
#(
    parameter int PEND_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_req_n,
    input  logic              acc_busy,
    input  logic [PEND_W-1:0] pend_cnt,
    output logic              hold_ack_n,
    output logic              bus_drive_en,
    output logic              int_stall
);
    localparam int SYNC_N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic     req_s;
    logic     idle;
    bha_out_t outs;

    bha_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .req_n_async(hold_req_n), .req_sync(req_s)
    );

    bha_idle #(.PEND_W(PEND_W)) u_idle (
        .acc_busy(acc_busy), .pend_cnt(pend_cnt), .idle(idle)
    );

    bha_fsm u_fsm (
        .clk(clk), .rst(rst), .req(req_s), .idle(idle), .outs(outs)
    );

    assign hold_ack_n   = outs.ack_n;
    assign bus_drive_en = outs.drive_en;
    assign int_stall    = outs.stall;
endmodule

// File: rtl/bus_hold_arbiter_chk.sv
module bus_hold_arbiter_chk #(
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              hold_req_n,
    input logic              acc_busy,
    input logic [PEND_W-1:0] pend_cnt,
    input logic              hold_ack_n,
    input logic              bus_drive_en,
    input logic              int_stall
);
    // R5
    granted_pads_off_chk: assert property (@(posedge clk) disable iff (rst)
        !hold_ack_n |-> (!bus_drive_en && int_stall));

    // R3 R4
    grant_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_ack_n) |-> $past(!acc_busy && (pend_cnt == '0)));

    // R2
    grant_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_ack_n) |-> $past(!hold_req_n, 3));

    // R6
    grant_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_ack_n && $past(!hold_req_n, 2)) |=> !hold_ack_n);

    // R7
    rearm_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack_n) |-> (bus_drive_en && int_stall));

    // R7
    rearm_stall_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack_n) |=> !int_stall);

    // R9
    stall_only_near_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_ack_n && int_stall) |-> $past(!hold_ack_n));
endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk #(.PEND_W(PEND_W)) u_chk (.*);

// File: tb/bus_hold_arbiter_test.sv
module bus_hold_arbiter_test;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          hold_req_n;
    logic          acc_busy;
    logic [PW-1:0] pend_cnt;
    logic          hold_ack_n;
    logic          bus_drive_en;
    logic          int_stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bus_hold_arbiter #(.PEND_W(PW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .hold_req_n(hold_req_n), .acc_busy(acc_busy),
        .pend_cnt(pend_cnt), .hold_ack_n(hold_ack_n),
        .bus_drive_en(bus_drive_en), .int_stall(int_stall)
    );

    task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s {ack_n,drive_en,stall} actual=%b expected=%b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] outs();
        return {hold_ack_n, bus_drive_en, int_stall};
    endfunction

    // advance n rising edges, then sample at the falling edge
    task automatic step(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic release_and_check();
        hold_req_n = 1'b1;
        step(1); chk("R6 held edge1", outs(), 3'b001);
        step(1); chk("R6 held edge2", outs(), 3'b001);
        step(1); chk("R7 rearm cycle", outs(), 3'b111);
        step(1); chk("R7 stall dropped", outs(), 3'b110);
    endtask

    task automatic t_reset();
        rst = 1'b1; hold_req_n = 1'b1; acc_busy = 1'b0; pend_cnt = '0;
        step(3);
        chk("R1 in reset", outs(), 3'b110);
        rst = 1'b0;
        step(5);
        chk("R1 idle no request", outs(), 3'b110);
    endtask

    task automatic t_idle_grant();
        hold_req_n = 1'b0;
        step(1); chk("R2 not after edge1", outs(), 3'b110);
        step(1); chk("R2 not after edge2", outs(), 3'b110);
        step(1); chk("R2 R5 grant after edge3", outs(), 3'b001);
        acc_busy = 1'b1; pend_cnt = 4'd7;
        step(3); chk("R6 busy while granted", outs(), 3'b001);
        acc_busy = 1'b0; pend_cnt = '0;
        release_and_check();
    endtask

    task automatic t_busy_wait();
        acc_busy = 1'b1;
        hold_req_n = 1'b0;
        step(6); chk("R3 R9 busy holds grant", outs(), 3'b110);
        acc_busy = 1'b0;
        step(1); chk("R3 grant after busy clears", outs(), 3'b001);
        release_and_check();
    endtask

    task automatic t_pend_wait();
        pend_cnt = 4'd3;
        hold_req_n = 1'b0;
        step(5); chk("R4 R9 pend=3 holds grant", outs(), 3'b110);
        pend_cnt = 4'd2;
        step(1); chk("R4 pend=2 holds grant", outs(), 3'b110);
        pend_cnt = 4'd8;
        step(1); chk("R4 pend=8 holds grant", outs(), 3'b110);
        pend_cnt = 4'd0;
        step(1); chk("R4 grant after queue empty", outs(), 3'b001);
        release_and_check();
    endtask

    task automatic t_abort();
        acc_busy = 1'b1;
        hold_req_n = 1'b0;
        step(5); chk("R9 draining", outs(), 3'b110);
        hold_req_n = 1'b1;
        step(4); chk("R8 withdrawn", outs(), 3'b110);
        acc_busy = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step(1); chk("R8 no late grant", outs(), 3'b110);
        end
    endtask

    initial begin
        t_reset();
        t_idle_grant();
        t_busy_wait();
        t_pend_wait();
        t_abort();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule